// File: doc/BRIEF.md
# Control-Step Latency Monitor

This peripheral sits between an external plant model and a group of processor cores that run one control step per sample. When the plant side raises a step request, the block latches the sensor pair into readable registers, asserts an interrupt line to every core, and starts counting clock cycles. It stops counting on the cycle in which the last actuator value of the step is written. It then presents the actuator values, the measured span and a late flag to the plant side, and pulses a resume strobe.

A step that runs past its programmed period only raises a flag. The step is never cut short, and the actuator values still leave at completion. Only one designated core may read sensors or write actuators, the step-done register and the period register. Any core may acknowledge interrupts and read status. A request that arrives during an active step waits in a single pending slot and starts one cycle after the active step completes.

Top module: `step_timing_monitor`

## Requirements
- R1: After reset all interrupt lines, the resume strobe, the actuator outputs, the step-cycle output and the late flag are 0. The period register (word 8) reads DEF_PERIOD and the status register (word 9) reads 0.
- R2: A step request while idle latches sensor 0 (bits SENS_W-1:0 of `sens_i`) into word 0 and sensor 1 into word 1. On the same clock edge it sets every interrupt line.
- R3: `step_cycles_o` equals the number of clock edges from the edge that raised the interrupts up to and including the edge that took the finishing write. The finishing write's edge also registers `act_o`, `step_late_o` and the count, and `resume_o` is high for exactly the following cycle.
- R4: A master write to word 6 (step done) finishes the active step.
- R5: With AUTO_DONE=1, the step also finishes on the master write that completes writes to all four actuator words (2..5) within the step.
- R6: `step_late_o` is 1 when the count is strictly greater than the period; a count equal to the period is not late. A late step still completes and presents its actuator values.
- R7: Status bit 0 is a sticky violation flag and bit 1 a sticky request-overflow flag; a read of word 9 returns them and clears both. Bit 2 shows an active step, bit 3 a pending request.
- R8: Writes to words 2..6 and 8 from a core other than MASTER_ID have no effect, and such a core reads words 0 and 1 as 0.
- R9: Interrupt line k stays high until a write to word 7 with data bit k set, from any core.
- R10: A request during an active step is held with its sensor values and sets the overflow flag. It starts on the edge after the active step's finishing edge, and interrupts rise then.
- R11: The cycle count saturates at 2^CNT_W-1 instead of wrapping.
- R12: The master can write the period in word 8, and the new value is used for the late decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req_i | input | 1 | One-cycle pulse: new step's sensors are valid |
| sens_i | input | 2*SENS_W | Sensor values, sensor 0 in the low bits |
| resume_o | output | 1 | One-cycle pulse after a step completes |
| act_o | output | 4*ACT_W | Actuator values of the last completed step, actuator 0 low |
| step_cycles_o | output | CNT_W | Measured span of the last completed step |
| step_late_o | output | 1 | Last completed step overran the period |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_id_i | input | ID_W | Identity of the accessing core |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid one cycle after the read strobe |
| irq_o | output | NCORES | One interrupt line per core |

## Verification
The bench builds the block with three cores, a 6-bit counter, a period of 20 cycles and AUTO_DONE=1. With the small counter, saturation at 63 is reached after a short stall. With the short period, the bench can place steps exactly on, one cycle over and well over the deadline. With three cores, a partial acknowledge can be seen to leave the other interrupt lines held. With AUTO_DONE=1, both finishing paths are covered: some steps end on the fourth actuator write and others on an explicit done write after only two actuator writes.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int ADDR_W    = 4;
  localparam int NUM_ACT   = 4;
  localparam int NUM_SENS  = 2;
  localparam int ACT_IDX_W = $clog2(NUM_ACT);

  localparam logic [ADDR_W-1:0] A_SENS0  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SENS1  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ACT0   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ACT1   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACT2   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ACT3   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DONE   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(10);
endpackage

// File: rtl/stm_cycle_ctr.sv
module stm_cycle_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] span_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // span including the edge that stops the count, saturated
  assign span_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (stop_i) begin
        busy_o <= 1'b0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stm_irq_bank.sv
module stm_irq_bank #(
  parameter int NCORES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              ack_we_i,
  input  logic [NCORES-1:0] ack_mask_i,
  output logic [NCORES-1:0] irq_o
);
  for (genvar k = 0; k < NCORES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_o[k] <= 1'b0;
      end else if (set_i) begin
        irq_o[k] <= 1'b1;
      end else if (ack_we_i && ack_mask_i[k]) begin
        irq_o[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stm_io_regs.sv
module stm_io_regs import stm_pkg::*; #(
  parameter int SENS_W = 16,
  parameter int ACT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture_i,
  input  logic [NUM_SENS*SENS_W-1:0] sens_d_i,
  input  logic                     act_we_i,
  input  logic [ACT_IDX_W-1:0]     act_idx_i,
  input  logic [ACT_W-1:0]         act_wdata_i,
  input  logic                     track_i,
  input  logic                     clr_mask_i,
  output logic [NUM_SENS*SENS_W-1:0] sens_q_o,
  output logic [NUM_ACT*ACT_W-1:0] act_q_o,
  output logic [NUM_ACT*ACT_W-1:0] act_next_o,
  output logic                     all_written_o
);
  logic [NUM_ACT-1:0] hit;
  logic [NUM_ACT-1:0] mask_q;
  logic [ACT_W-1:0]   act_r [NUM_ACT];

  always_comb begin
    hit = '0;
    if (act_we_i) hit[act_idx_i] = 1'b1;
  end

  assign all_written_o = &(mask_q | hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (clr_mask_i) begin
      mask_q <= '0;
    end else if (track_i) begin
      mask_q <= mask_q | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_q_o <= '0;
    end else if (capture_i) begin
      sens_q_o <= sens_d_i;
    end
  end

  for (genvar k = 0; k < NUM_ACT; k++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) begin
        act_r[k] <= '0;
      end else if (hit[k]) begin
        act_r[k] <= act_wdata_i;
      end
    end
    assign act_q_o[k*ACT_W +: ACT_W]    = act_r[k];
    assign act_next_o[k*ACT_W +: ACT_W] = hit[k] ? act_wdata_i : act_r[k];
  end
endmodule

// File: rtl/step_timing_monitor.sv
module step_timing_monitor import stm_pkg::*; #(
  parameter int NCORES     = 2,
  parameter int ID_W       = 2,
  parameter int MASTER_ID  = 0,
  parameter int SENS_W     = 16,
  parameter int ACT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 2000,
  parameter int AUTO_DONE  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step_req_i,
  input  logic [NUM_SENS*SENS_W-1:0] sens_i,
  output logic                       resume_o,
  output logic [NUM_ACT*ACT_W-1:0]   act_o,
  output logic [CNT_W-1:0]           step_cycles_o,
  output logic                       step_late_o,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [ID_W-1:0]            bus_id_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [NCORES-1:0]          irq_o
);
  localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_PERIOD);

  logic                       master_ok, is_act;
  logic                       wr_act, wr_done, wr_ack, wr_period, rd_status;
  logic [ACT_IDX_W-1:0]       act_idx;
  logic                       busy, start, finish, all_written;
  logic [CNT_W-1:0]           span;
  logic [CNT_W-1:0]           period_q;
  logic                       pend_q, ovf_q, viol_q;
  logic [NUM_SENS*SENS_W-1:0] pend_sens_q, cap_sens, sens_q;
  logic [NUM_ACT*ACT_W-1:0]   act_q, act_next;
  logic                       unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  // ---------------- access decode ----------------
  assign master_ok = (bus_id_i == ID_W'(MASTER_ID));
  assign is_act    = (bus_addr_i >= A_ACT0) && (bus_addr_i <= A_ACT3);
  assign act_idx   = ACT_IDX_W'(bus_addr_i - A_ACT0);
  assign wr_act    = bus_wr_i && master_ok && is_act;
  assign wr_done   = bus_wr_i && master_ok && (bus_addr_i == A_DONE);
  assign wr_period = bus_wr_i && master_ok && (bus_addr_i == A_PERIOD);
  assign wr_ack    = bus_wr_i && (bus_addr_i == A_ACK);
  assign rd_status = bus_rd_i && (bus_addr_i == A_STATUS);

  // ---------------- step sequencing ----------------
  assign start    = !busy && (step_req_i || pend_q);
  assign cap_sens = pend_q ? pend_sens_q : sens_i;

  if (AUTO_DONE != 0) begin : g_auto_done
    assign finish = busy && (wr_done || (wr_act && all_written));
  end else begin : g_reg_done
    logic unused_all;
    assign unused_all = all_written;
    assign finish = busy && wr_done;
  end

  stm_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .stop_i  (finish),
    .busy_o  (busy),
    .span_o  (span)
  );

  stm_irq_bank #(.NCORES(NCORES)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .set_i      (start),
    .ack_we_i   (wr_ack),
    .ack_mask_i (bus_wdata_i[NCORES-1:0]),
    .irq_o      (irq_o)
  );

  stm_io_regs #(.SENS_W(SENS_W), .ACT_W(ACT_W)) u_io (
    .clk           (clk),
    .rst           (rst),
    .capture_i     (start),
    .sens_d_i      (cap_sens),
    .act_we_i      (wr_act),
    .act_idx_i     (act_idx),
    .act_wdata_i   (bus_wdata_i[ACT_W-1:0]),
    .track_i       (busy),
    .clr_mask_i    (start),
    .sens_q_o      (sens_q),
    .act_q_o       (act_q),
    .act_next_o    (act_next),
    .all_written_o (all_written)
  );

  // ---------------- pending request slot ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_sens_q <= '0;
    end else if (start) begin
      if (pend_q && step_req_i) begin
        pend_sens_q <= sens_i;
      end else begin
        pend_q <= 1'b0;
      end
    end else if (busy && step_req_i && !pend_q) begin
      pend_q      <= 1'b1;
      pend_sens_q <= sens_i;
    end
  end

  // ---------------- result and status ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      resume_o      <= 1'b0;
      act_o         <= '0;
      step_cycles_o <= '0;
      step_late_o   <= 1'b0;
      viol_q        <= 1'b0;
      ovf_q         <= 1'b0;
      period_q      <= PERIOD_RST;
    end else begin
      resume_o <= finish;
      if (finish) begin
        act_o         <= act_next;
        step_cycles_o <= span;
        step_late_o   <= (span > period_q);
      end
      if (finish && (span > period_q)) begin
        viol_q <= 1'b1;
      end else if (rd_status) begin
        viol_q <= 1'b0;
      end
      if (busy && step_req_i) begin
        ovf_q <= 1'b1;
      end else if (rd_status) begin
        ovf_q <= 1'b0;
      end
      if (wr_period) begin
        period_q <= bus_wdata_i[CNT_W-1:0];
      end
    end
  end

  // ---------------- read port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        A_SENS0:  bus_rdata_o <= master_ok ? DATA_W'(sens_q[SENS_W-1:0]) : '0;
        A_SENS1:  bus_rdata_o <= master_ok ? DATA_W'(sens_q[2*SENS_W-1:SENS_W]) : '0;
        A_ACT0, A_ACT1, A_ACT2, A_ACT3:
                  bus_rdata_o <= DATA_W'(act_q[act_idx*ACT_W +: ACT_W]);
        A_PERIOD: bus_rdata_o <= DATA_W'(period_q);
        A_STATUS: bus_rdata_o <= DATA_W'({pend_q, busy, ovf_q, viol_q});
        A_LAST:   bus_rdata_o <= DATA_W'(step_cycles_o);
        default:  bus_rdata_o <= '0;
      endcase
    end else begin
      bus_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/stm_chk.sv
module stm_chk #(
  parameter int NCORES    = 2,
  parameter int ID_W      = 2,
  parameter int MASTER_ID = 0,
  parameter int CNT_W     = 16,
  parameter int ACT_BITS  = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic [CNT_W-1:0]    span,
  input logic [NCORES-1:0]   irq,
  input logic                resume,
  input logic                bus_wr,
  input logic [ID_W-1:0]     bus_id,
  input logic [ACT_BITS-1:0] act_q,
  input logic                viol,
  input logic                rd_status
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2: every interrupt line is up on the edge the step begins
  a_r2_irq_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (&irq));

  // R3: resume strobe lasts one cycle and follows the end of the step
  a_r3_resume_pulse: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);
  a_r3_resume_idle: assert property (@(posedge clk) disable iff (rst)
    resume |-> !busy);

  // R11: once saturated the span stays at the maximum
  a_r11_span_saturates: assert property (@(posedge clk) disable iff (rst)
    (busy && span == CNT_MAX) |=> (span == CNT_MAX));

  // R8: writes from a non-master core leave the actuator registers untouched
  a_r8_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_id != ID_W'(MASTER_ID)) |=> $stable(act_q));

  // R7: violation flag holds until a status read
  a_r7_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    (viol && !rd_status) |=> viol);
endmodule

bind step_timing_monitor stm_chk #(
  .NCORES    (NCORES),
  .ID_W      (ID_W),
  .MASTER_ID (MASTER_ID),
  .CNT_W     (CNT_W),
  .ACT_BITS  (stm_pkg::NUM_ACT*ACT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .span      (span),
  .irq       (irq_o),
  .resume    (resume_o),
  .bus_wr    (bus_wr_i),
  .bus_id    (bus_id_i),
  .act_q     (act_q),
  .viol      (viol_q),
  .rd_status (rd_status)
);

// File: tb/test_step_timing_monitor.sv
module test_step_timing_monitor;
  localparam int NC = 3, IDW = 2, SW = 16, AW = 16, DW = 32, CW = 6, PER = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic step_req = 1'b0;
  logic [2*SW-1:0] sens = '0;
  logic resume_o, late_o;
  logic [4*AW-1:0] act_o;
  logic [CW-1:0] cycles_o;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [IDW-1:0] bus_id = '0;
  logic [3:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [NC-1:0] irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [15:0] mact [4];
  logic [DW-1:0] d;

  always #4 clk = ~clk;

  step_timing_monitor #(.NCORES(NC), .ID_W(IDW), .MASTER_ID(0), .SENS_W(SW), .ACT_W(AW),
    .DATA_W(DW), .CNT_W(CW), .DEF_PERIOD(PER), .AUTO_DONE(1)) i_step_timing_monitor (
    .clk(clk), .rst(rst), .step_req_i(step_req), .sens_i(sens), .resume_o(resume_o),
    .act_o(act_o), .step_cycles_o(cycles_o), .step_late_o(late_o), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_id_i(bus_id), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq));

  // {sensor0, sensor1, idle gap, finish by done register}
  localparam logic [40:0] VEC [4] = '{
    {16'h1234, 16'h00ab, 8'd0,  1'b1},
    {16'hbeef, 16'h0001, 8'd14, 1'b0},
    {16'h0f0f, 16'hf0f0, 8'd15, 1'b0},
    {16'h7777, 16'h8888, 8'd16, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int id, input int addr, input logic [DW-1:0] data);
    bus_wr = 1'b1; bus_id = IDW'(id); bus_addr = 4'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_id = '0;
    if (id == 0 && addr >= 2 && addr <= 5) mact[addr-2] = data[15:0];
  endtask

  task automatic rd(input int id, input int addr, output logic [DW-1:0] data);
    bus_rd = 1'b1; bus_id = IDW'(id); bus_addr = 4'(addr);
    @(negedge clk);
    bus_rd = 1'b0; bus_id = '0;
    data = bus_rdata;
  endtask

  task automatic go(input logic [15:0] s0, input logic [15:0] s1);
    step_req = 1'b1; sens = {s1, s0};
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic chk_acts(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, act_o[k*AW +: AW], mact[k]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mact[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 resume", resume_o, 0);
    chk("R1 cycles", cycles_o, 0);
    chk("R1 late", late_o, 0);
    chk("R1 act", act_o, 0);
    rd(0, 8, d); chk("R1 period", d, PER);
    rd(0, 9, d); chk("R1 status", d, 0);

    // table of steps
    for (int i = 0; i < 4; i++) begin
      logic [15:0] s0, s1;
      logic [7:0] gap;
      logic ud;
      int expc;
      {s0, s1, gap, ud} = VEC[i];
      go(s0, s1);
      chk("R2 irq", irq, 3'b111);
      rd(0, 0, d); chk("R2 sens0", d, s0);
      rd(0, 1, d); chk("R2 sens1", d, s1);
      repeat (gap) tick();
      if (ud) begin
        wr(0, 2, s0 + 16'd1);
        wr(0, 3, s1 + 16'd2);
        wr(0, 6, 1);               // R4 done register
        expc = 2 + gap + 3;
      end else begin
        for (int k = 0; k < 4; k++) wr(0, 2 + k, s0 ^ 16'(k * 257)); // R5 fourth write ends
        expc = 2 + gap + 4;
      end
      chk("R3 resume", resume_o, 1);
      chk(ud ? "R4 cycles" : "R5 cycles", cycles_o, expc);
      chk("R6 late", late_o, (expc > PER) ? 1 : 0);
      chk_acts("R6 acts");
      tick();
      chk("R3 resume one cycle", resume_o, 0);
      wr(0, 7, 3'b111);
    end

    // R7 sticky flags, read clear
    rd(1, 9, d); chk("R7 status sticky", d, 4'b0001);
    rd(1, 9, d); chk("R7 status cleared", d, 0);

    // R8 / R9 foreign accesses and partial acknowledge
    go(16'h5a5a, 16'h0000);
    chk("R9 irq set", irq, 3'b111);
    wr(2, 7, 3'b010);
    chk("R9 partial ack", irq, 3'b101);
    rd(1, 0, d); chk("R8 foreign sensor read", d, 0);
    wr(1, 2, 16'hdead);
    wr(1, 6, 1);
    chk("R8 foreign done ignored", resume_o, 0);
    chk("R9 irq held", irq, 3'b101);
    wr(0, 6, 1);
    chk("R4 resume", resume_o, 1);
    chk("R4 cycles", cycles_o, 5);
    chk_acts("R8 act unchanged");
    wr(0, 7, 3'b111);

    // R10 pending request
    go(16'h1111, 16'h2222);
    go(16'h3333, 16'h4444);
    rd(0, 9, d); chk("R10 status", d, 4'b1110);
    wr(0, 7, 3'b111);
    chk("R9 ack all", irq, 0);
    wr(0, 6, 1);
    chk("R10 first done", resume_o, 1);
    chk("R10 no irq yet", irq, 0);
    tick();
    chk("R10 pending started", irq, 3'b111);
    rd(0, 0, d); chk("R10 pending sensor", d, 16'h3333);
    rd(0, 9, d); chk("R10 status after", d, 4'b0100);
    wr(0, 6, 1);
    chk("R10 second done", resume_o, 1);
    wr(0, 7, 3'b111);

    // R11 saturation
    go(16'h0001, 16'h0002);
    repeat (70) tick();
    wr(0, 6, 1);
    chk("R11 saturated", cycles_o, 63);
    chk("R6 late at saturation", late_o, 1);

    // R12 period write
    wr(0, 8, 40);
    rd(0, 8, d); chk("R12 period readback", d, 40);
    go(16'h0003, 16'h0004);
    repeat (25) tick();
    wr(0, 6, 1);
    chk("R12 cycles", cycles_o, 26);
    chk("R12 not late", late_o, 0);
    rd(0, 10, d); chk("R3 last span word", d, 26);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule